// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

This block is an 8-bit up-counter fed by a prescaled copy of the system clock. Software picks one of eight division ratios and one of two personalities. As an interval timer, each counter wrap raises an interrupt request that stays up until software acknowledges it. As a watchdog, each wrap drives a fixed-length pulse on an external overflow pin, which board logic can use to reset the system.

Software reaches the block through a small synchronous register port with two locations. One is a control/status byte holding the mode, the run enable, the clock select and a sticky overflow flag. The other is the counter itself, which can be read and loaded. To acknowledge the flag, software must first read it as 1 and then write 0 to it. This stops a stray write from dismissing an overflow it never saw.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset the control/status byte (address 0) reads 0x18, the counter (address 1) reads 0x00, and both `irq_o` and `wdt_ovf_o` are low.
- R2: While the run bit (control bit 5) is 0, the counter holds 0x00 and does not advance. A write to address 1 in that state has no effect.
- R3: With the run bit at 1, the counter advances once every D system clocks. D follows control bits 2..0: 000→2, 001→64, 010→128, 011→256, 100→512, 101→1024, 110→4096, 111→8192. The prescaler is cleared while the timer is stopped, so a full pass from 0x00 to the wrap takes 256·D clocks counted from the edge that sets the run bit.
- R4: Control bits 4 and 3 always read as 1. Writes to them are ignored.
- R5: With control bit 6 at 0 (interval mode), a wrap from 0xFF sets the flag (control bit 7). `irq_o` is high exactly while the flag is set in this mode, and `wdt_ovf_o` stays low.
- R6: With control bit 6 at 1 (watchdog mode), a wrap sets the flag and drives `wdt_ovf_o` high for exactly 128 system clocks. `irq_o` stays low.
- R7: The flag clears only on a write to address 0 with bit 7 at 0 that follows a read of address 0 (`rd_en_i` high) which returned bit 7 as 1. A write of 0 without that read leaves the flag set. Writing 1 to bit 7 never sets it.
- R8: A write to address 1 while running loads the counter. If the write falls in the same cycle as a count tick, the loaded value wins over the increment.
- R9: On a wrap the counter returns to 0x00 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 1 | Register select: 0 control/status, 1 counter |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe, used to arm the flag acknowledge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interval-mode interrupt request |
| wdt_ovf_o | output | 1 | Watchdog-mode overflow pulse |

## Verification
The assertions assume that `rst_i` is synchronous and held across at least one edge. They also assume that a counter load is the only way, other than a tick or a stop, for the counter to change. Because of that, a step check can treat any change that is not +1 as coming from a write or from a stop.

The pulse-length check assumes that no new wrap lands inside a running watchdog pulse. The stimulus meets this: every watchdog run uses a ratio and a preload that put the next wrap well beyond 128 clocks, and the timer is stopped before the mode or ratio is changed. Bus strobes are driven only on falling edges and last one cycle each, so every write and read maps to exactly one rising edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W   = 8;
    localparam int CNT_W    = 8;
    localparam int SEL_W    = 3;
    localparam int N_SEL    = 1 << SEL_W;
    localparam int PRE_W    = 13;
    localparam int PULSE_LEN = 128;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_WATCHDOG = 1'b1
    } wdt_mode_e;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_CNT  = 1'b1
    } wdt_reg_e;

    localparam logic [1:0] RSVD_READ = 2'b11;

    // control/status byte as seen on the bus
    typedef struct packed {
        logic        ovf_flag;
        wdt_mode_e   mode;
        logic        run;
        logic [1:0]  rsvd;
        logic [SEL_W-1:0] clk_sel;
    } wdt_ctrl_t;

    // number of low prescaler bits that must be all ones for a tick
    function automatic int div_log2(input int sel);
        case (sel)
            0:       return 1;
            1:       return 6;
            2:       return 7;
            3:       return 8;
            4:       return 9;
            5:       return 10;
            6:       return 12;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_q;
    logic [N_SEL-1:0] taps;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < N_SEL; g++) begin : g_tap
        localparam int LOW_BITS = div_log2(g);
        assign taps[g] = &pre_q[LOW_BITS-1:0];
    end

    assign tick_o = run_i & taps[sel_i];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) cnt_q <= '0;
        else if (load_i)     cnt_q <= load_val_i;
        else if (tick_i)     cnt_q <= cnt_q + 1'b1;
    end

    // a load in the tick cycle suppresses both the step and the wrap
    assign wrap_o = run_i & tick_i & ~load_i & (cnt_q == CNT_TOP);
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic             wr_flag_i,
    input  logic             wr_mode_i,
    input  logic             wr_run_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic             wrap_i,
    output wdt_ctrl_t        ctrl_o
);
    wdt_mode_e        mode_q;
    logic             run_q;
    logic [SEL_W-1:0] sel_q;
    logic             flag_q;
    logic             armed_q;
    logic             ack;

    assign ack = wr_i & ~wr_flag_i & armed_q & flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= MODE_INTERVAL;
            run_q  <= 1'b0;
            sel_q  <= '0;
        end else if (wr_i) begin
            mode_q <= wdt_mode_e'(wr_mode_i);
            run_q  <= wr_run_i;
            sel_q  <= wr_sel_i;
        end
    end

    // sticky flag: set by wrap, cleared only by an armed write of 0
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (wrap_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (ack) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        ctrl_o.ovf_flag = flag_q;
        ctrl_o.mode     = mode_q;
        ctrl_o.run      = run_q;
        ctrl_o.rsvd     = RSVD_READ;
        ctrl_o.clk_sel  = sel_q;
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 128
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fire_i,
    output logic active_o
);
    localparam int W = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] RELOAD = W'(LEN - 1);

    logic [W-1:0] left_q;
    logic         active_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else if (fire_i) begin
            active_q <= 1'b1;
            left_q   <= RELOAD;
        end else if (active_q) begin
            if (left_q == '0) active_q <= 1'b0;
            else              left_q   <= left_q - 1'b1;
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
    import wdt_pkg::*;
#(
    parameter int OVF_PULSE = PULSE_LEN
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              wdt_ovf_o
);
    wdt_ctrl_t        ctrl_q;
    logic             wr_ctrl, wr_cnt, rd_ctrl;
    logic             tick_w, wrap_w, fire_w;
    logic             run_w, mode_wd_w, flag_w;
    logic [CNT_W-1:0] cnt_q;

    assign wr_ctrl = wr_en_i & (wdt_reg_e'(addr_i) == REG_CTRL);
    assign wr_cnt  = wr_en_i & (wdt_reg_e'(addr_i) == REG_CNT);
    assign rd_ctrl = rd_en_i & (wdt_reg_e'(addr_i) == REG_CTRL);

    wdt_ctrl_reg u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (wr_ctrl),
        .rd_i      (rd_ctrl),
        .wr_flag_i (wdata_i[7]),
        .wr_mode_i (wdata_i[6]),
        .wr_run_i  (wdata_i[5]),
        .wr_sel_i  (wdata_i[SEL_W-1:0]),
        .wrap_i    (wrap_w),
        .ctrl_o    (ctrl_q)
    );

    assign run_w     = ctrl_q.run;
    assign mode_wd_w = (ctrl_q.mode == MODE_WATCHDOG);
    assign flag_w    = ctrl_q.ovf_flag;

    wdt_prescaler u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (run_w),
        .sel_i  (ctrl_q.clk_sel),
        .tick_o (tick_w)
    );

    wdt_counter u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .run_i      (run_w),
        .tick_i     (tick_w),
        .load_i     (wr_cnt),
        .load_val_i (wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt_q),
        .wrap_o     (wrap_w)
    );

    assign fire_w = wrap_w & mode_wd_w;

    wdt_pulse #(.LEN(OVF_PULSE)) u_pulse (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .fire_i   (fire_w),
        .active_o (wdt_ovf_o)
    );

    assign irq_o   = flag_w & ~mode_wd_w;
    assign rdata_o = (wdt_reg_e'(addr_i) == REG_CTRL) ? DATA_W'(ctrl_q) : DATA_W'(cnt_q);

endmodule

// File: rtl/wdt_interval_timer_chk.sv
module wdt_interval_timer_chk
    import wdt_pkg::*;
#(
    parameter int OVF_PULSE = PULSE_LEN
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic              wdt_ovf_o,
    input logic              run_w,
    input logic              mode_wd_w,
    input logic              flag_w,
    input logic              wrap_w,
    input logic [CNT_W-1:0]  cnt_q
);
    logic        wr_cnt;
    logic [15:0] hi_len_q;

    assign wr_cnt = wr_en_i & addr_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || !wdt_ovf_o || wrap_w) hi_len_q <= '0;
        else                               hi_len_q <= hi_len_q + 1'b1;
    end

    assert_stopped_cnt_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_w |=> (cnt_q == '0));

    assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q != $past(cnt_q)) |->
            ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || $past(wr_cnt) || !$past(run_w)));

    assert_rsvd_ones_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == 1'b0) |-> (rdata_o[4:3] == 2'b11));

    assert_irq_source_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (flag_w && !mode_wd_w));

    assert_pulse_start_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wdt_ovf_o) |-> $past(wrap_w && mode_wd_w));

    assert_pulse_len_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_ovf_o |-> (hi_len_q < 16'(OVF_PULSE)));

    assert_flag_from_wrap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(flag_w) |-> $past(wrap_w));

endmodule

bind wdt_interval_timer wdt_interval_timer_chk #(.OVF_PULSE(OVF_PULSE)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .wdt_ovf_o (wdt_ovf_o),
    .run_w     (run_w),
    .mode_wd_w (mode_wd_w),
    .flag_w    (flag_w),
    .wrap_w    (wrap_w),
    .cnt_q     (cnt_q)
);

// File: tb/wdt_interval_timer_bench.sv
module wdt_interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, ovf;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdt_interval_timer u_wdt_interval_timer (
        .clk_i     (clk),
        .rst_i     (rst),
        .addr_i    (addr),
        .wr_en_i   (wr),
        .rd_en_i   (rd),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .wdt_ovf_o (ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ack_and_stop();
        logic [7:0] d;
        bus_rd(1'b0, d);
        bus_wr(1'b0, 8'h00);
    endtask

    function automatic int ratio(input int sel);
        case (sel)
            0: return 2;    1: return 64;   2: return 128;  3: return 256;
            4: return 512;  5: return 1024; 6: return 4096; default: return 8192;
        endcase
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        peek(1'b0, d); check("R1 ctrl reset", d, 8'h18);
        peek(1'b1, d); check("R1 cnt reset", d, 8'h00);
        check("R1 irq reset", irq, 0);
        check("R1 ovf reset", ovf, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        bus_wr(1'b0, 8'h07);
        peek(1'b0, d); check("R4 rsvd after 0x07", d, 8'h1F);
        bus_wr(1'b0, 8'h00);
        peek(1'b0, d); check("R4 rsvd after 0x00", d, 8'h18);
    endtask

    task automatic t_stopped();
        logic [7:0] d;
        bus_wr(1'b1, 8'h55);
        peek(1'b1, d); check("R2 load ignored when stopped", d, 8'h00);
        repeat (50) @(negedge clk);
        peek(1'b1, d); check("R2 cnt held", d, 8'h00);
        peek(1'b0, d); check("R2 no flag", d[7], 0);
    endtask

    task automatic t_full_pass(input int sel);
        logic [7:0] d;
        int n = 0;
        bus_wr(1'b0, 8'h20 | 8'(sel));
        addr = 1'b0;
        while (!irq && n < 300000) begin @(negedge clk); n++; end
        check("R3 full pass length", n, 256 * ratio(sel));
        check("R5 irq on wrap", irq, 1);
        check("R5 no ovf pin in interval mode", ovf, 0);
        peek(1'b0, d); check("R5 flag bit", d[7], 1);
        peek(1'b1, d); check("R9 cnt wraps to 0", d, 8'h00);
        if (sel == 0) begin
            repeat (2) @(negedge clk);
            peek(1'b1, d); check("R9 cnt continues", d, 8'h01);
        end
        ack_and_stop();
    endtask

    task automatic t_each_ratio();
        for (int s = 0; s < 8; s++) begin
            int n = 1;
            bus_wr(1'b0, 8'h20 | 8'(s));
            bus_wr(1'b1, 8'hFF);
            addr = 1'b0;
            while (!irq && n < 20000) begin @(negedge clk); n++; end
            check($sformatf("R3 ratio sel=%0d", s), n, ratio(s));
            ack_and_stop();
        end
    endtask

    task automatic t_load_priority();
        logic [7:0] d;
        bus_wr(1'b0, 8'h20);
        @(negedge clk);
        bus_wr(1'b1, 8'h40);              // lands on a tick edge
        peek(1'b1, d); check("R8 load beats tick", d, 8'h40);
        @(negedge clk);
        peek(1'b1, d); check("R8 held between ticks", d, 8'h40);
        @(negedge clk);
        peek(1'b1, d); check("R8 counts from loaded value", d, 8'h41);
        bus_wr(1'b0, 8'h00);
    endtask

    task automatic t_flag_ack();
        logic [7:0] d;
        bus_wr(1'b0, 8'h20);
        bus_wr(1'b1, 8'hFF);
        repeat (2) @(negedge clk);
        bus_wr(1'b0, 8'h00);              // no prior read
        peek(1'b0, d); check("R7 unarmed write keeps flag", d, 8'h98);
        check("R7 irq still up", irq, 1);
        bus_rd(1'b0, d); check("R7 read sees flag", d, 8'h98);
        bus_wr(1'b0, 8'h80);
        peek(1'b0, d); check("R7 write of 1 keeps flag", d, 8'h98);
        bus_wr(1'b0, 8'h00);
        peek(1'b0, d); check("R7 armed write clears", d, 8'h18);
        check("R7 irq drops", irq, 0);
        bus_wr(1'b0, 8'h80);
        peek(1'b0, d); check("R7 write of 1 does not set", d, 8'h18);
    endtask

    task automatic t_watchdog();
        logic [7:0] d;
        int n = 0;
        int hi = 0;
        int irq_seen = 0;
        bus_wr(1'b0, 8'h60);
        bus_wr(1'b1, 8'hFF);
        while (!ovf && n < 100) begin @(negedge clk); n++; end
        check("R6 pulse start delay", n, 1);
        while (ovf && hi < 1000) begin
            if (irq) irq_seen = 1;
            hi++;
            @(negedge clk);
        end
        check("R6 pulse length", hi, 128);
        check("R6 no irq in watchdog mode", irq_seen, 0);
        peek(1'b0, d); check("R6 flag set", d[7], 1);
        ack_and_stop();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_stopped();
        t_full_pass(0);
        t_full_pass(1);
        t_each_ratio();
        t_load_priority();
        t_flag_ack();
        t_watchdog();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule